// File: doc/BRIEF.md
# Interrupt Line Acceptance and Coalescing Engine

This engine sits between a bank of interrupt input lines and the logic that builds outgoing interrupt messages. Each cycle it takes per-line set and clear events, and the live fields of every line's routing entry: the mask bit, the trigger mode and the vector. From these it decides when a line is delivered. A delivery is a one-cycle pulse that carries the line index and its vector.

For each line it keeps three pieces of state: the sampled line level, a remote-pending flag for level-triggered lines, and a queued service request. Repeated requests are merged until software acknowledges them. Software acknowledges by writing an end-of-interrupt with a vector. Any line that is still high after that acknowledgement is serviced again. One designated line, the periodic-clock tick line, also has its own pending flag, so that it is coalesced even when it runs edge-triggered. A strobe tells the engine that an entry was rewritten. When a level-triggered line is unmasked while it is high, that strobe services it at once.

Requests are held in a per-line request vector. The lowest-numbered request is retired each cycle: it is either delivered or dropped by its gating. The outputs are registered.

Top module: `coal_engine`

## Requirements
- R1: A clear event sets the line's stored level to low and never causes a delivery by itself. A set and a clear on the same line in the same cycle act as a clear.
- R2: A set event on an edge-triggered line (`pin_level` bit 0) whose stored level is already high is ignored: no request is queued.
- R3: A set event records the level as high even on a masked line (`pin_mask` bit 1). A request for a line that is masked when it is retired is dropped without delivery.
- R4: A level-triggered line (`pin_level` bit 1) sets its remote-pending flag when it is delivered. While that flag is set, further requests for the line are dropped.
- R5: The tick line (index `RTC_PIN`, default 8) has its own pending flag. The flag is set when the line is delivered in edge mode. While the flag is set, no delivery of the tick line happens. An end-of-interrupt whose vector equals the tick line's vector clears the flag.
- R6: An end-of-interrupt clears the remote-pending flag of every level-triggered line whose vector (`pin_vector[p*VW +: VW]`) equals the written vector.
- R7: After an end-of-interrupt, every line whose stored level is high gets a new service request, whatever its vector.
- R8: An entry-write strobe for a line that is level-triggered, unmasked and high queues a service request for that line.
- R9: Requests are retired in ascending line order, one per cycle. A delivery is presented on the outputs one clock after the cycle in which the request was retired. Requests that are not yet retired stay queued.
- R10: After reset, no line is high, no flag or request is set, and `dlv_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_set | input | N | Per-line assert event |
| line_clr | input | N | Per-line deassert event |
| pin_mask | input | N | Per-line mask, 1 = masked |
| pin_level | input | N | Per-line trigger mode, 1 = level, 0 = edge |
| pin_vector | input | N*VW | Per-line vector, line p at bits p*VW +: VW |
| entry_wr | input | 1 | Strobe: an entry was rewritten |
| entry_wr_pin | input | IW | Index of the rewritten entry |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VW | Vector carried by the end-of-interrupt |
| dlv_valid | output | 1 | One-cycle delivery pulse |
| dlv_pin | output | IW | Index of the delivered line |
| dlv_vector | output | VW | Vector of the delivered line |

## Verification
Set, clear, end-of-interrupt and entry-write events are sampled at a clock edge and change the request vector at that edge. The lowest queued request is retired in the next cycle, and its delivery appears after the edge that follows, so an idle line shows a response two edges after its stimulus. When several requests are queued, each one lands a further cycle later. The bench's reference model steps once per edge on the same inputs and predicts the registered outputs for the state before that edge, and the outputs are compared shortly after every rising edge. Per-line delivery counts are checked after a drain of several idle cycles, so that queued and re-injected requests have settled before a count is judged.

// File: rtl/coal_pkg.sv
package coal_pkg;
    // Trigger-mode encoding of each bit of pin_level
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/coal_pick.sv
// Lowest-index finder over a request vector
module coal_pick #(
    parameter int N  = 24,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/coal_vec_match.sv
// Per-line compare of the end-of-interrupt vector against each entry
module coal_vec_match #(
    parameter int N  = 24,
    parameter int VW = 8
) (
    input  logic [N*VW-1:0] vecs,
    input  logic [VW-1:0]   key,
    input  logic            en,
    output logic [N-1:0]    hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = en && (vecs[g*VW +: VW] == key);
    end
endmodule

// File: rtl/coal_engine.sv
module coal_engine #(
    parameter int N       = 24,
    parameter int VW      = 8,
    parameter int RTC_PIN = 8,
    localparam int IW     = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    line_set,
    input  logic [N-1:0]    line_clr,
    input  logic [N-1:0]    pin_mask,
    input  logic [N-1:0]    pin_level,
    input  logic [N*VW-1:0] pin_vector,
    input  logic            entry_wr,
    input  logic [IW-1:0]   entry_wr_pin,
    input  logic            eoi_valid,
    input  logic [VW-1:0]   eoi_vector,
    output logic            dlv_valid,
    output logic [IW-1:0]   dlv_pin,
    output logic [VW-1:0]   dlv_vector
);
    import coal_pkg::*;

    localparam logic [IW-1:0] RTC_IDX = IW'(RTC_PIN);

    typedef struct packed {
        logic [N-1:0]  level;
        logic [N-1:0]  remote;
        logic [N-1:0]  req;
        logic          rtc_pend;
        logic          dlv_valid;
        logic [IW-1:0] dlv_pin;
        logic [VW-1:0] dlv_vec;
    } state_t;

    state_t st_d, st_q;

    logic          pick_hit;
    logic [IW-1:0] pick_idx;
    logic [N-1:0]  eoi_hit;
    logic          go;

    coal_pick #(.N(N), .IW(IW)) u_pick (
        .req (st_q.req),
        .hit (pick_hit),
        .idx (pick_idx)
    );

    coal_vec_match #(.N(N), .VW(VW)) u_match (
        .vecs (pin_vector),
        .key  (eoi_vector),
        .en   (eoi_valid),
        .hit  (eoi_hit)
    );

    always_comb begin
        st_d           = st_q;
        st_d.dlv_valid = 1'b0;
        st_d.dlv_pin   = '0;
        st_d.dlv_vec   = '0;
        go             = 1'b0;

        // retire the lowest queued request, gated by mask and pending flags
        if (pick_hit) begin
            st_d.req[pick_idx] = 1'b0;
            go = !pin_mask[pick_idx]
              && !(pin_level[pick_idx] && st_q.remote[pick_idx])
              && !(pick_idx == RTC_IDX && st_q.rtc_pend);
        end

        // acknowledgement clears flags before a new delivery may set them
        st_d.remote = st_q.remote & ~(eoi_hit & pin_level);
        if (eoi_hit[RTC_PIN]) st_d.rtc_pend = 1'b0;

        if (go) begin
            st_d.dlv_valid = 1'b1;
            st_d.dlv_pin   = pick_idx;
            st_d.dlv_vec   = pin_vector[pick_idx*VW +: VW];
            if (pin_level[pick_idx]) st_d.remote[pick_idx] = 1'b1;
            else if (pick_idx == RTC_IDX) st_d.rtc_pend = 1'b1;
        end

        // line events: clear wins over set, edge re-assert while high is dropped
        for (int p = 0; p < N; p++) begin
            if (line_clr[p]) begin
                st_d.level[p] = 1'b0;
            end else if (line_set[p]
                         && !(trig_e'(pin_level[p]) == TRIG_EDGE && st_q.level[p])) begin
                st_d.level[p] = 1'b1;
                st_d.req[p]   = 1'b1;
            end
        end

        // re-inject every line still high after an acknowledgement
        if (eoi_valid) st_d.req = st_d.req | st_d.level;

        // entry rewrite unmasking a high level line
        if (entry_wr && pin_level[entry_wr_pin] && !pin_mask[entry_wr_pin]
            && st_d.level[entry_wr_pin]) begin
            st_d.req[entry_wr_pin] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dlv_valid  = st_q.dlv_valid;
    assign dlv_pin    = st_q.dlv_pin;
    assign dlv_vector = st_q.dlv_vec;

    // R5
    rtc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rtc_pend |=> !(dlv_valid && dlv_pin == RTC_IDX));

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R3
        masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pin_mask[g] |=> !(dlv_valid && dlv_pin == IW'(g)));
        // R4
        remote_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.remote[g] && pin_level[g]) |=> !(dlv_valid && dlv_pin == IW'(g)));
        // R4
        remote_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.remote[g]) |-> (dlv_valid && dlv_pin == IW'(g)));
    end
endmodule

// File: tb/coal_engine_test.sv
module coal_engine_test;
    localparam int NP  = 24;
    localparam int VW  = 8;
    localparam int IW  = $clog2(NP);
    localparam int RTC = 8;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] a_in = '0, d_in = '0, msk = '0, lm = '0;
    logic [NP*VW-1:0] vecs = '0;
    logic wr = 1'b0;
    logic [IW-1:0] wr_pin = '0;
    logic eoi = 1'b0;
    logic [VW-1:0] eoi_vec = '0;
    logic dv;
    logic [IW-1:0] dp;
    logic [VW-1:0] dvec;

    int checks = 0, fails = 0;
    string tag = "R10";
    bit done = 0;
    int dcount [NP];
    int seq_pin [$];
    bit m_lvl [NP];
    bit m_rem [NP];
    bit m_req [NP];
    bit m_rtc = 0;

    coal_engine #(.N(NP), .VW(VW), .RTC_PIN(RTC)) uut (
        .clk(clk), .rst_n(rst_n), .line_set(a_in), .line_clr(d_in),
        .pin_mask(msk), .pin_level(lm), .pin_vector(vecs),
        .entry_wr(wr), .entry_wr_pin(wr_pin),
        .eoi_valid(eoi), .eoi_vector(eoi_vec),
        .dlv_valid(dv), .dlv_pin(dp), .dlv_vector(dvec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_step(output bit ev, output int ep);
        int pk;
        bit go;
        ev = 0;
        ep = 0;
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_lvl[p] = 0; m_rem[p] = 0; m_req[p] = 0;
            end
            m_rtc = 0;
            return;
        end
        pk = -1;
        for (int p = 0; p < NP; p++) if (m_req[p] && pk < 0) pk = p;
        go = 0;
        if (pk >= 0) begin
            m_req[pk] = 0;
            go = !msk[pk] && !(lm[pk] && m_rem[pk]) && !(pk == RTC && m_rtc);
        end
        if (eoi) begin
            for (int p = 0; p < NP; p++) begin
                if (vecs[p*VW +: VW] == eoi_vec) begin
                    if (lm[p]) m_rem[p] = 0;
                    if (p == RTC) m_rtc = 0;
                end
            end
        end
        if (go) begin
            ev = 1;
            ep = pk;
            if (lm[pk]) m_rem[pk] = 1;
            else if (pk == RTC) m_rtc = 1;
        end
        for (int p = 0; p < NP; p++) begin
            if (d_in[p]) m_lvl[p] = 0;
            else if (a_in[p] && !(!lm[p] && m_lvl[p])) begin
                m_lvl[p] = 1;
                m_req[p] = 1;
            end
        end
        if (eoi) for (int p = 0; p < NP; p++) if (m_lvl[p]) m_req[p] = 1;
        if (wr && lm[wr_pin] && !msk[wr_pin] && m_lvl[wr_pin]) m_req[wr_pin] = 1;
    endtask

    task automatic tick();
        bit ev;
        int ep;
        @(posedge clk);
        #1;
        model_step(ev, ep);
        chk(dv == ev, tag, int'(dv), int'(ev));
        if (ev) begin
            chk(dp == IW'(ep), tag, int'(dp), ep);
            chk(dvec == vecs[ep*VW +: VW], tag, int'(dvec), int'(vecs[ep*VW +: VW]));
        end
        if (dv) begin
            dcount[dp]++;
            seq_pin.push_back(int'(dp));
        end
        a_in = '0; d_in = '0; wr = 1'b0; eoi = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        for (int p = 0; p < NP; p++) begin
            vecs[p*VW +: VW] = VW'(8'h20 + p);
            dcount[p] = 0;
        end
        lm[10] = 1'b1; lm[12] = 1'b1;
        msk[5] = 1'b1; msk[12] = 1'b1;

        // R10: reset state
        idle(3);
        chk(dv == 1'b0, "R10", int'(dv), 0);
        rst_n = 1'b1;
        idle(2);
        chk(dv == 1'b0, "R10", int'(dv), 0);

        // R2: repeated edge assert is ignored
        tag = "R2";
        base = dcount[3];
        a_in[3] = 1'b1; tick();
        a_in[3] = 1'b1; tick(); idle(4);
        chk(dcount[3] - base == 1, "R2", dcount[3] - base, 1);
        d_in[3] = 1'b1; tick();
        a_in[3] = 1'b1; tick(); idle(4);
        chk(dcount[3] - base == 2, "R2", dcount[3] - base, 2);
        d_in[3] = 1'b1; tick();

        // R1: deassert and simultaneous set+clear give nothing
        tag = "R1";
        base = dcount[4];
        a_in[4] = 1'b1; d_in[4] = 1'b1; tick(); idle(4);
        d_in[4] = 1'b1; tick(); idle(4);
        chk(dcount[4] - base == 0, "R1", dcount[4] - base, 0);
        a_in[4] = 1'b1; tick(); idle(4);
        chk(dcount[4] - base == 1, "R1", dcount[4] - base, 1);
        d_in[4] = 1'b1; tick();

        // R3: masked assert records level but does not deliver
        tag = "R3";
        base = dcount[5];
        a_in[5] = 1'b1; tick(); idle(4);
        chk(dcount[5] - base == 0, "R3", dcount[5] - base, 0);
        msk[5] = 1'b0;
        a_in[5] = 1'b1; tick(); idle(4);
        chk(dcount[5] - base == 0, "R3", dcount[5] - base, 0);
        d_in[5] = 1'b1; tick();
        a_in[5] = 1'b1; tick(); idle(4);
        chk(dcount[5] - base == 1, "R3", dcount[5] - base, 1);
        d_in[5] = 1'b1; tick();

        // R4: level coalescing by remote-pending
        tag = "R4";
        base = dcount[10];
        a_in[10] = 1'b1; tick(); idle(4);
        chk(dcount[10] - base == 1, "R4", dcount[10] - base, 1);
        d_in[10] = 1'b1; tick();
        a_in[10] = 1'b1; tick(); idle(4);
        chk(dcount[10] - base == 1, "R4", dcount[10] - base, 1);

        // R7: acknowledgement re-injects a line still high
        tag = "R7";
        eoi = 1'b1; eoi_vec = 8'h2A; tick(); idle(4);
        chk(dcount[10] - base == 2, "R7", dcount[10] - base, 2);

        // R6: acknowledgement clears remote-pending
        tag = "R6";
        d_in[10] = 1'b1; tick();
        eoi = 1'b1; eoi_vec = 8'h2A; tick(); idle(4);
        chk(dcount[10] - base == 2, "R6", dcount[10] - base, 2);
        a_in[10] = 1'b1; tick(); idle(4);
        chk(dcount[10] - base == 3, "R6", dcount[10] - base, 3);
        d_in[10] = 1'b1; tick(); idle(2);

        // R5: tick line has its own pending flag
        tag = "R5";
        base = dcount[RTC];
        a_in[RTC] = 1'b1; tick(); idle(4);
        chk(dcount[RTC] - base == 1, "R5", dcount[RTC] - base, 1);
        d_in[RTC] = 1'b1; tick();
        a_in[RTC] = 1'b1; tick(); idle(4);
        chk(dcount[RTC] - base == 1, "R5", dcount[RTC] - base, 1);
        eoi = 1'b1; eoi_vec = 8'h28; tick(); idle(4);
        chk(dcount[RTC] - base == 2, "R5", dcount[RTC] - base, 2);
        d_in[RTC] = 1'b1; tick(); idle(2);

        // R8: entry rewrite unmasking a high level line
        tag = "R8";
        base = dcount[12];
        a_in[12] = 1'b1; tick(); idle(4);
        chk(dcount[12] - base == 0, "R8", dcount[12] - base, 0);
        msk[12] = 1'b0; wr = 1'b1; wr_pin = IW'(12); tick(); idle(4);
        chk(dcount[12] - base == 1, "R8", dcount[12] - base, 1);
        d_in[12] = 1'b1; tick(); idle(2);

        // R9: ascending order, one per cycle
        tag = "R9";
        seq_pin.delete();
        a_in[2] = 1'b1; a_in[6] = 1'b1; a_in[15] = 1'b1; tick(); idle(5);
        chk(seq_pin.size() == 3, "R9", seq_pin.size(), 3);
        if (seq_pin.size() == 3) begin
            chk(seq_pin[0] == 2, "R9", seq_pin[0], 2);
            chk(seq_pin[1] == 6, "R9", seq_pin[1], 6);
            chk(seq_pin[2] == 15, "R9", seq_pin[2], 15);
        end
        d_in[2] = 1'b1; d_in[6] = 1'b1; d_in[15] = 1'b1; tick(); idle(2);

        done = 1;
        summary();
        $finish;
    end
endmodule